// File: doc/BRIEF.md
# UART Receive Buffer and Error Status

This block sits between a UART receive shifter and the processor. When the shifter reports a finished character, the block loads the character into a receive buffer register. At that same clock edge it decides whether the character has an overrun, framing or parity error. It keeps a receive complete flag, one flag for each error kind and an error sum flag. It also raises a receive interrupt request. A mode select chooses whether that request fires on every completed character or only on characters that carry an error.

The processor side has these controls:
- a strobe that reads the low-order byte of the buffer;
- a receive enable;
- the parity and stop-bit settings;
- an interrupt-clear strobe.

The error flags clear in different ways. Reading the buffer removes framing and parity errors. An overrun stays set until receive enable is dropped. Dropping receive enable and raising it again reinitialises the buffer and every flag.

Top module: `rx_status`

## Requirements
- R1: After reset, the buffer is zero and complete, every error flag, the error sum and the interrupt request are all 0.
- R2: A transfer happens when shiftDone=1 and rxEnable=1 at a clock edge. At that edge the buffer takes shiftData and rxComplete becomes 1.
- R3: With parityOn=1, a transfer sets parityErr when the number of 1s across the data bits and the parity bit is odd and parityOdd=0, or even and parityOdd=1. With parityOn=0 parity is never flagged.
- R4: A transfer sets framingErr when shiftStopCnt differs from the configured count. The configured count is 1 when twoStop=0 and 2 when twoStop=1.
- R5: A transfer with rxComplete=1 and no read in the same cycle sets overrunErr. The new character is still loaded.
- R6: overrunErr is not cleared by a buffer read. It clears only while rxEnable=0.
- R7: A read (lowByteRead=1) in a cycle with no transfer clears rxComplete, framingErr and parityErr.
- R8: When a read and a transfer fall in the same cycle:
  - rxComplete stays 1;
  - framingErr and parityErr take the new character's results;
  - no overrun is flagged.
- R9: errSum is 1 exactly when at least one of overrunErr, framingErr or parityErr is 1.
- R10: With irqModeErr=0, every transfer sets irqReq.
- R11: With irqModeErr=1, a transfer sets irqReq only if it produces an overrun, framing or parity error.
- R12: irqReq holds until an irqClear pulse. A set in the same cycle as a clear wins.
- R13: While rxEnable=0:
  - the buffer, rxComplete and all error flags are held at 0;
  - shiftDone is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shiftDone | input | 1 | Shifter has a finished character |
| shiftData | input | DATA_W | Character bits from the shifter |
| shiftParity | input | 1 | Received parity bit |
| shiftStopCnt | input | STOP_W | Number of valid stop bits detected |
| rxEnable | input | 1 | Receive enable; low flushes buffer and flags |
| parityOn | input | 1 | Parity checking enabled |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| twoStop | input | 1 | 1 = two stop bits expected, 0 = one |
| lowByteRead | input | 1 | Processor read of the buffer low byte |
| irqModeErr | input | 1 | 1 = interrupt on errors only, 0 = on every completion |
| irqClear | input | 1 | Clears the interrupt request |
| rxBuf | output | DATA_W | Receive buffer register |
| rxComplete | output | 1 | Buffer holds an unread character |
| overrunErr | output | 1 | Overrun error flag |
| framingErr | output | 1 | Framing error flag |
| parityErr | output | 1 | Parity error flag |
| errSum | output | 1 | OR of the three error flags |
| irqReq | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach from the ports is a buffer read that lands in exactly the same cycle as a character transfer. Here the read must neither cause an overrun nor wipe out the new character's flags. The bench raises shiftDone and lowByteRead on the same falling edge. It sends a first good character so that rxComplete is already 1, and gives the second character a bad parity bit. An overrun with no read also needs two transfers back to back. After it, the bench reads the buffer to show that the overrun flag survives the read.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic loadBuf;
    logic flushBuf;
  } dpStrobe_t;

  // datapath -> control check results for the character on the shifter
  typedef struct packed {
    logic parityBad;
    logic frameBad;
  } chkResult_t;
endpackage

// File: rtl/rx_status_dp.sv
module rx_status_dp
  import rx_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STOP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] shiftData,
  input  logic              shiftParity,
  input  logic [STOP_W-1:0] shiftStopCnt,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic              twoStop,
  output chkResult_t        chk,
  output logic [DATA_W-1:0] rxBuf
);
  localparam logic [STOP_W-1:0] ONE_STOP = STOP_W'(1);
  localparam logic [STOP_W-1:0] TWO_STOP = STOP_W'(2);

  logic onesOdd;
  logic [STOP_W-1:0] cfgStops;

  always_comb begin
    onesOdd       = ^{shiftData, shiftParity};
    cfgStops      = twoStop ? TWO_STOP : ONE_STOP;
    chk.parityBad = parityOn && (onesOdd != parityOdd);
    chk.frameBad  = (shiftStopCnt != cfgStops);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rxBuf <= '0;
    else if (strb.flushBuf) rxBuf <= '0;
    else if (strb.loadBuf)  rxBuf <= shiftData;
  end

  // R2
  buf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadBuf |=> rxBuf == $past(shiftData));

  // R13
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.loadBuf && strb.flushBuf));
endmodule

// File: rtl/rx_status_ctrl.sv
module rx_status_ctrl
  import rx_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shiftDone,
  input  logic       rxEnable,
  input  logic       lowByteRead,
  input  logic       irqModeErr,
  input  logic       irqClear,
  input  chkResult_t chk,
  output dpStrobe_t  strb,
  output logic       rxComplete,
  output logic       overrunErr,
  output logic       framingErr,
  output logic       parityErr,
  output logic       errSum,
  output logic       irqReq
);
  logic take;
  logic newOverrun;
  logic anyNewErr;
  logic setIrq;

  always_comb begin
    take          = rxEnable && shiftDone;
    newOverrun    = take && rxComplete && !lowByteRead;
    anyNewErr     = chk.frameBad || chk.parityBad || newOverrun;
    setIrq        = take && (irqModeErr ? anyNewErr : 1'b1);
    strb.loadBuf  = take;
    strb.flushBuf = !rxEnable;
    errSum        = overrunErr || framingErr || parityErr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxComplete <= 1'b0;
      overrunErr <= 1'b0;
      framingErr <= 1'b0;
      parityErr  <= 1'b0;
    end else if (!rxEnable) begin
      rxComplete <= 1'b0;
      overrunErr <= 1'b0;
      framingErr <= 1'b0;
      parityErr  <= 1'b0;
    end else if (take) begin
      rxComplete <= 1'b1;
      overrunErr <= overrunErr || newOverrun;
      framingErr <= chk.frameBad  || (framingErr && !lowByteRead);
      parityErr  <= chk.parityBad || (parityErr  && !lowByteRead);
    end else if (lowByteRead) begin
      rxComplete <= 1'b0;
      framingErr <= 1'b0;
      parityErr  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqReq <= 1'b0;
    else        irqReq <= setIrq || (irqReq && !irqClear);
  end

  // R6
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrunErr && rxEnable) |=> overrunErr);

  // R5
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrunErr) |-> ($past(rxComplete) && $past(shiftDone)));

  // R13
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rxEnable |=> (!rxComplete && !errSum));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lowByteRead && rxEnable && !shiftDone) |=> (!rxComplete && !framingErr && !parityErr));

  // R10
  irq_mode0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shiftDone && rxEnable && !irqModeErr) |=> irqReq);

  // R11
  irq_mode1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irqReq) && $past(irqModeErr)) |-> errSum);

  // R12
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irqReq && !irqClear) |=> irqReq);
endmodule

// File: rtl/rx_status.sv
module rx_status
  import rx_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STOP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shiftDone,
  input  logic [DATA_W-1:0] shiftData,
  input  logic              shiftParity,
  input  logic [STOP_W-1:0] shiftStopCnt,
  input  logic              rxEnable,
  input  logic              parityOn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              lowByteRead,
  input  logic              irqModeErr,
  input  logic              irqClear,
  output logic [DATA_W-1:0] rxBuf,
  output logic              rxComplete,
  output logic              overrunErr,
  output logic              framingErr,
  output logic              parityErr,
  output logic              errSum,
  output logic              irqReq
);
  dpStrobe_t  strb;
  chkResult_t chk;

  rx_status_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .shiftDone(shiftDone), .rxEnable(rxEnable),
    .lowByteRead(lowByteRead), .irqModeErr(irqModeErr), .irqClear(irqClear),
    .chk(chk), .strb(strb), .rxComplete(rxComplete), .overrunErr(overrunErr),
    .framingErr(framingErr), .parityErr(parityErr), .errSum(errSum),
    .irqReq(irqReq)
  );

  rx_status_dp #(.DATA_W(DATA_W), .STOP_W(STOP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .shiftData(shiftData),
    .shiftParity(shiftParity), .shiftStopCnt(shiftStopCnt), .parityOn(parityOn),
    .parityOdd(parityOdd), .twoStop(twoStop), .chk(chk), .rxBuf(rxBuf)
  );
endmodule

// File: tb/tb_rx_status.sv
`timescale 1ns/1ps
module tb_rx_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shiftDone = 1'b0;
  logic [7:0] shiftData = '0;
  logic shiftParity = 1'b0;
  logic [1:0] shiftStopCnt = 2'd1;
  logic rxEnable = 1'b1;
  logic parityOn = 1'b1;
  logic parityOdd = 1'b0;
  logic twoStop = 1'b0;
  logic lowByteRead = 1'b0;
  logic irqModeErr = 1'b0;
  logic irqClear = 1'b0;
  logic [7:0] rxBuf;
  logic rxComplete, overrunErr, framingErr, parityErr, errSum, irqReq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_status dut (
    .clk(clk), .rst_n(rst_n), .shiftDone(shiftDone), .shiftData(shiftData),
    .shiftParity(shiftParity), .shiftStopCnt(shiftStopCnt), .rxEnable(rxEnable),
    .parityOn(parityOn), .parityOdd(parityOdd), .twoStop(twoStop),
    .lowByteRead(lowByteRead), .irqModeErr(irqModeErr), .irqClear(irqClear),
    .rxBuf(rxBuf), .rxComplete(rxComplete), .overrunErr(overrunErr),
    .framingErr(framingErr), .parityErr(parityErr), .errSum(errSum), .irqReq(irqReq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one-cycle character transfer; returns at the falling edge after capture
  task automatic sendChar(logic [7:0] d, logic p, logic [1:0] s, logic rd = 1'b0, logic clr = 1'b0);
    @(negedge clk);
    shiftData = d; shiftParity = p; shiftStopCnt = s;
    shiftDone = 1'b1; lowByteRead = rd; irqClear = clr;
    @(negedge clk);
    shiftDone = 1'b0; lowByteRead = 1'b0; irqClear = 1'b0;
  endtask

  task automatic doRead();
    @(negedge clk); lowByteRead = 1'b1;
    @(negedge clk); lowByteRead = 1'b0;
  endtask

  task automatic doIrqClear();
    @(negedge clk); irqClear = 1'b1;
    @(negedge clk); irqClear = 1'b0;
  endtask

  task automatic toggleEnable();
    @(negedge clk); rxEnable = 1'b0;
    @(negedge clk); rxEnable = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 buf", rxBuf, 0);
    check("R1 complete", rxComplete, 0);
    check("R1 errSum", errSum, 0);
    check("R1 irq", irqReq, 0);
  endtask

  task automatic t_good();
    sendChar(8'hA5, ^8'hA5, 2'd1);
    check("R2 buf", rxBuf, 8'hA5);
    check("R2 complete", rxComplete, 1);
    check("R3 parity ok", parityErr, 0);
    check("R4 framing ok", framingErr, 0);
    check("R10 irq on completion", irqReq, 1);
    repeat (3) @(negedge clk);
    check("R12 irq held", irqReq, 1);
    doRead();
    check("R7 read clears complete", rxComplete, 0);
    doIrqClear();
    check("R12 irq cleared", irqReq, 0);
  endtask

  task automatic t_parity();
    sendChar(8'h03, 1'b1, 2'd1);            // 3 ones, even parity -> error
    check("R3 even bad", parityErr, 1);
    check("R9 sum", errSum, 1);
    doRead();
    check("R7 read clears parity", parityErr, 0);
    check("R9 sum low", errSum, 0);
    parityOdd = 1'b1;
    sendChar(8'h03, 1'b0, 2'd1);            // 2 ones, odd parity -> error
    check("R3 odd bad", parityErr, 1);
    doRead();
    sendChar(8'h03, 1'b1, 2'd1);            // 3 ones, odd parity -> ok
    check("R3 odd ok", parityErr, 0);
    doRead();
    parityOn = 1'b0; parityOdd = 1'b0;
    sendChar(8'h03, 1'b1, 2'd1);
    check("R3 parity off", parityErr, 0);
    doRead();
    parityOn = 1'b1;
    doIrqClear();
  endtask

  task automatic t_framing();
    sendChar(8'h10, ^8'h10, 2'd0);
    check("R4 missing stop", framingErr, 1);
    doRead();
    check("R7 read clears framing", framingErr, 0);
    twoStop = 1'b1;
    sendChar(8'h10, ^8'h10, 2'd1);
    check("R4 one of two", framingErr, 1);
    doRead();
    sendChar(8'h10, ^8'h10, 2'd2);
    check("R4 two of two", framingErr, 0);
    doRead();
    twoStop = 1'b0;
    sendChar(8'h10, ^8'h10, 2'd2);
    check("R4 two with one set", framingErr, 1);
    doRead();
    doIrqClear();
  endtask

  task automatic t_overrun();
    sendChar(8'h11, ^8'h11, 2'd1);
    check("R5 no overrun first", overrunErr, 0);
    sendChar(8'h22, ^8'h22, 2'd1);
    check("R5 overrun", overrunErr, 1);
    check("R5 new data loaded", rxBuf, 8'h22);
    check("R9 sum overrun", errSum, 1);
    doRead();
    check("R6 read keeps overrun", overrunErr, 1);
    check("R7 complete cleared", rxComplete, 0);
    toggleEnable();
    check("R6 enable clears overrun", overrunErr, 0);
    check("R13 buffer flushed", rxBuf, 0);
    doIrqClear();
  endtask

  task automatic t_same();
    sendChar(8'h44, ^8'h44, 2'd1);
    sendChar(8'h55, 1'b1, 2'd1, 1'b1);     // read collides with bad-parity char
    check("R8 complete stays", rxComplete, 1);
    check("R8 no overrun", overrunErr, 0);
    check("R8 new parity applied", parityErr, 1);
    check("R8 buf", rxBuf, 8'h55);
    doRead();
    doIrqClear();
  endtask

  task automatic t_mode1();
    irqModeErr = 1'b1;
    sendChar(8'h66, ^8'h66, 2'd1);
    check("R11 good char no irq", irqReq, 0);
    doRead();
    sendChar(8'h66, ~(^8'h66), 2'd1);
    check("R11 error irq", irqReq, 1);
    doRead();
    sendChar(8'h66, ^8'h66, 2'd0, 1'b0, 1'b1); // clear collides with framing set
    check("R12 set beats clear", irqReq, 1);
    doRead();
    doIrqClear();
    sendChar(8'h01, ^8'h01, 2'd1);
    sendChar(8'h02, ^8'h02, 2'd1);
    check("R11 overrun irq", irqReq, 1);
    toggleEnable();
    doIrqClear();
    irqModeErr = 1'b0;
  endtask

  task automatic t_disabled();
    @(negedge clk); rxEnable = 1'b0;
    sendChar(8'hAA, 1'b1, 2'd0);
    check("R13 ignored buf", rxBuf, 0);
    check("R13 ignored complete", rxComplete, 0);
    check("R13 ignored errors", errSum, 0);
    check("R13 ignored irq", irqReq, 0);
    @(negedge clk); rxEnable = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_parity();
    t_framing();
    t_overrun();
    t_same();
    t_mode1();
    t_disabled();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule